// File: doc/BRIEF.md
# Interrupt Control and Flag Register

An 8-bit read/write register that collects three interrupt sources for a small CPU core and drives a single request line. The sources are a timer rollover pulse, a rising edge on an external interrupt pin, and a mismatch on any masked general-purpose input pin. Each source has a sticky flag and an enable bit. A global enable and a group enable for outside peripheral requests sit above the source enables.

Flags record events whatever the enables say, so software can poll them with interrupts disabled. A flag is cleared only by a register write. The pin-change flag compares the synchronised pins against a reference value that is captured each time the port is read. When a hardware event and a software clear reach the same flag in the same cycle, the event wins.

Top module: `irq_ctl_reg`

## Requirements
- R1: Register bits, MSB first: 7 global enable, 6 peripheral-group enable, 5 timer enable, 4 external-pin enable, 3 pin-change enable, 2 timer flag, 1 external-pin flag, 0 pin-change flag. A write with `reg_we_i` loads all eight bits at the clock edge. The read data shows the register contents combinationally, and with no event pending it returns the written value.
- R2: While `rst_ni` is low, bits 7 to 1 read 0 and `irq_o` is 0.
- R3: Reset does not change the pin-change flag (bit 0).
- R4: A flag sets on its event regardless of its own enable and the global enable. The timer flag reads 1 after the edge at which `tmr_roll_i` is sampled high.
- R5: A set flag stays set through any number of idle cycles and clears only when software writes 0 to it.
- R6: If a hardware set and a software write of 0 hit the same flag at the same edge, the flag is 1 afterwards.
- R7: The external pin passes through two flip-flops. A rising edge sets bit 1 at the third clock edge after the pin goes high. A steady high level or a falling edge sets nothing.
- R8: Pins go through one sync stage. A pulse on `port_rd_i` latches the synced pins as the reference, and the reference is 0 after reset. Bit 0 sets one edge after a synced pin with its mask bit at 1 differs from the reference. Pins with mask bit 0 are ignored.
- R9: `irq_o` = bit7 AND ((b5 AND b2) OR (b4 AND b1) OR (b3 AND b0) OR (b6 AND any peripheral request)). `irq_o` is 0 whenever bit 7 is 0.
- R10: Peripheral requests reach `irq_o` only while bit 6 is set, and they are never latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Register contents |
| tmr_roll_i | input | 1 | Timer rollover pulse |
| ext_pin_i | input | 1 | External interrupt pin (asynchronous) |
| gp_pins_i | input | NUM_PINS | General-purpose input pins |
| chg_mask_i | input | NUM_PINS | Per-pin change-detect enable |
| port_rd_i | input | 1 | Port read strobe, captures the reference |
| periph_req_i | input | NUM_PERIPH | Peripheral interrupt requests |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
A hardware flag event and a software write to that same flag can fall in the same cycle. This is the race the flag priority has to settle. The bench provokes it directly by writing 0 to the timer flag while `tmr_roll_i` is high, and expects the flag to read 1 afterwards. Random traffic also lands writes on pin-change and external-edge events, and each such cycle is judged against a bench model in which the set wins.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int REG_W  = 8;
  localparam int N_FLAG = 3;
  localparam int N_EN   = REG_W - N_FLAG;
  // flag positions; rollover has the highest bit
  localparam int FLG_CHG = 0;
  localparam int FLG_EXT = 1;
  localparam int FLG_TMR = 2;

  typedef struct packed {
    logic glb_en;
    logic grp_en;
    logic tmr_en;
    logic ext_en;
    logic chg_en;
  } irq_en_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R7
endmodule

// File: rtl/irq_pin_change.sv
module irq_pin_change #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic                rd_i,
  output logic                chg_o
);
  logic [NUM_PINS-1:0] pins_q, ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_q <= '0;
      ref_q  <= '0;
    end else begin
      pins_q <= pins_i;
      if (rd_i) ref_q <= pins_q;
    end
  end

  assign chg_o = |((pins_q ^ ref_q) & mask_i);

  AST_MASK_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !chg_o); // R8
endmodule

// File: rtl/irq_flag_bit.sv
module irq_flag_bit #(
  parameter bit HAS_RST = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic we_i,
  input  logic wd_i,
  output logic q_o
);
  logic nxt;
  // hardware set has priority over a software write
  assign nxt = set_i | (we_i ? wd_i : q_o);

  if (HAS_RST) begin : g_rst
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= 1'b0;
      else         q_o <= nxt;
    end
  end else begin : g_norst
    always_ff @(posedge clk_i) q_o <= nxt;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !(we_i && !wd_i)) |=> q_o); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wd_i && !set_i) |=> !q_o); // R5
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int NUM_PERIPH  = 4,
  parameter int EXT_STAGES  = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [REG_W-1:0]      reg_wdata_i,
  output logic [REG_W-1:0]      reg_rdata_o,
  input  logic                  tmr_roll_i,
  input  logic                  ext_pin_i,
  input  logic [NUM_PINS-1:0]   gp_pins_i,
  input  logic [NUM_PINS-1:0]   chg_mask_i,
  input  logic                  port_rd_i,
  input  logic [NUM_PERIPH-1:0] periph_req_i,
  output logic                  irq_o
);
  irq_en_t           en_q;
  logic [N_FLAG-1:0] flg_q, flg_set;
  logic              ext_rise, chg_any, periph_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= '0;
    else if (reg_we_i) en_q <= irq_en_t'(reg_wdata_i[REG_W-1:N_FLAG]);
  end

  irq_edge_sync #(.STAGES(EXT_STAGES)) u_ext (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (ext_pin_i),
    .rise_o(ext_rise)
  );

  irq_pin_change #(.NUM_PINS(NUM_PINS)) u_chg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(gp_pins_i),
    .mask_i(chg_mask_i),
    .rd_i  (port_rd_i),
    .chg_o (chg_any)
  );

  always_comb begin
    flg_set          = '0;
    flg_set[FLG_TMR] = tmr_roll_i;
    flg_set[FLG_EXT] = ext_rise;
    flg_set[FLG_CHG] = chg_any;
  end

  // the pin-change flag keeps its value across reset
  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    irq_flag_bit #(.HAS_RST(i != FLG_CHG)) u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (flg_set[i]),
      .we_i  (reg_we_i),
      .wd_i  (reg_wdata_i[i]),
      .q_o   (flg_q[i])
    );
  end

  assign reg_rdata_o = {en_q, flg_q};
  assign periph_any  = |periph_req_i;
  assign irq_o = en_q.glb_en & ((en_q.tmr_en & flg_q[FLG_TMR]) |
                                (en_q.ext_en & flg_q[FLG_EXT]) |
                                (en_q.chg_en & flg_q[FLG_CHG]) |
                                (en_q.grp_en & periph_any));

  always_comb begin
    if (!rst_ni) begin
      AST_RST_CLEAR: assert (reg_rdata_o[REG_W-1:1] == '0 && !irq_o); // R2
    end
  end

  AST_GLB_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[REG_W-1] |-> !irq_o); // R9
  AST_TMR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_roll_i |=> reg_rdata_o[FLG_TMR]); // R4
  AST_GRP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_rdata_o[REG_W-2] && !(|(reg_rdata_o[REG_W-3:N_FLAG] & reg_rdata_o[N_FLAG-1:0])))
      |-> !irq_o); // R10
endmodule

// File: tb/irq_ctl_reg_test.sv
module irq_ctl_reg_test;
  localparam int NP = 8;
  localparam int NQ = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          t_we = 1'b0, t_tmr = 1'b0, t_ext = 1'b0, t_rd = 1'b0;
  logic [7:0]    t_wd = '0;
  logic [NP-1:0] t_pins = '0, t_mask = '0;
  logic [NQ-1:0] t_per = '0;
  logic [7:0]    rdata;
  logic          irq;

  int n_chk = 0, n_fail = 0;

  // bench model
  logic [4:0]    m_en = '0;
  logic [2:0]    m_flg = '0;
  logic          m_s1 = 0, m_s2 = 0, m_s3 = 0, known = 0;
  logic [NP-1:0] m_pins = '0, m_ref = '0;

  irq_ctl_reg #(.NUM_PINS(NP), .NUM_PERIPH(NQ)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(t_we), .reg_wdata_i(t_wd),
    .reg_rdata_o(rdata), .tmr_roll_i(t_tmr), .ext_pin_i(t_ext),
    .gp_pins_i(t_pins), .chg_mask_i(t_mask), .port_rd_i(t_rd),
    .periph_req_i(t_per), .irq_o(irq)
  );

  always #5 clk = ~clk;

  function automatic logic exp_irq(logic [4:0] en, logic [2:0] f, logic [NQ-1:0] p);
    return en[4] & ((en[2] & f[2]) | (en[1] & f[1]) | (en[0] & f[0]) | (en[3] & (|p)));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    logic [2:0] hw;
    logic [4:0] n_en;
    logic [2:0] n_flg;
    logic [NP-1:0] n_ref;
    logic [7:0] cm;
    hw    = {t_tmr, m_s2 & ~m_s3, |((m_pins ^ m_ref) & t_mask)};
    n_en  = t_we ? t_wd[7:3] : m_en;
    n_flg = hw | (t_we ? t_wd[2:0] : m_flg);
    n_ref = t_rd ? m_pins : m_ref;
    if (t_we) known = 1;
    @(posedge clk);
    m_en = n_en; m_flg = n_flg; m_ref = n_ref;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = t_ext; m_pins = t_pins;
    @(negedge clk);
    cm = known ? 8'hFF : 8'hFE;
    chk("R1 model", 32'(rdata & cm), 32'({m_en, m_flg} & cm));
    chk("R9 model", 32'(irq), 32'(exp_irq(m_en, known ? m_flg : 3'b000, t_per)));
    t_we = 0; t_tmr = 0; t_rd = 0;
  endtask

  task automatic wr(logic [7:0] v);
    t_we = 1; t_wd = v; step();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0;
    m_en = '0; m_flg[2:1] = '0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pins = '0; m_ref = '0;
    @(negedge clk);
    chk("R2 reset bits", 32'(rdata[7:1]), 0);
    chk("R2 reset irq", 32'(irq), 0);
    @(negedge clk);
    rst_ni = 1;
  endtask

  initial begin
    #1ms;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    wr(8'h00);
    // R1 read back
    wr(8'hF8); chk("R1 readback", 32'(rdata), 32'hF8);
    wr(8'h07); chk("R1 sw set flags", 32'(rdata), 32'h07);
    // R3 flag survives reset
    wr(8'h01);
    do_reset();
    chk("R3 bit0 kept", 32'(rdata[0]), 1);
    wr(8'h00);
    // R4 flag sets with enables off; R9 no request
    t_tmr = 1; step();
    chk("R4 tmr flag", 32'(rdata[2]), 1);
    chk("R9 glb off", 32'(irq), 0);
    // R5 sticky
    step(); step(); step();
    chk("R5 sticky", 32'(rdata[2]), 1);
    wr(8'h00); chk("R5 clear", 32'(rdata[2]), 0);
    // R6 set beats clear
    t_tmr = 1; t_we = 1; t_wd = 8'h00; step();
    chk("R6 set wins", 32'(rdata[2]), 1);
    wr(8'h00);
    // R7 external edge
    t_ext = 1; step(); step();
    chk("R7 not yet", 32'(rdata[1]), 0);
    step(); chk("R7 edge", 32'(rdata[1]), 1);
    wr(8'h00);
    step(); step(); step();
    chk("R7 level ignored", 32'(rdata[1]), 0);
    t_ext = 0; step(); step(); step();
    chk("R7 fall ignored", 32'(rdata[1]), 0);
    // R8 pin change
    t_mask = 8'h0F; t_pins = 8'h00; t_rd = 1; step();
    wr(8'h00);
    t_pins = 8'hF0; step(); step(); step();
    chk("R8 unmasked ignored", 32'(rdata[0]), 0);
    t_pins = 8'hF1; step();
    chk("R8 sync delay", 32'(rdata[0]), 0);
    step(); chk("R8 masked change", 32'(rdata[0]), 1);
    t_rd = 1; step();
    wr(8'h00); step();
    chk("R8 new reference", 32'(rdata[0]), 0);
    // R10 group gate, R9 formula
    t_per = 4'b0010; wr(8'hC0);
    chk("R10 periph on", 32'(irq), 1);
    wr(8'h80); chk("R10 group off", 32'(irq), 0);
    t_per = '0;
    wr(8'hA4); chk("R9 tmr source", 32'(irq), 1);
    wr(8'h24); chk("R9 glb gate", 32'(irq), 0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      t_we   = ($urandom % 8) == 0;
      t_wd   = 8'($urandom);
      t_tmr  = ($urandom % 16) == 0;
      if (($urandom % 6) == 0) t_ext = ~t_ext;
      if (($urandom % 4) == 0) t_pins = t_pins ^ NP'(1 << ($urandom % NP));
      if (($urandom % 50) == 0) t_mask = NP'($urandom);
      t_rd   = ($urandom % 8) == 0;
      t_per  = (($urandom % 4) == 0) ? NQ'($urandom) : '0;
      step();
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule